// File: doc/BRIEF.md
# EDO Page-Mode Burst Read Sequencer

This block reads a run of words from one row of an extended-data-out DRAM. It opens the row with a single fall of the row strobe, then pulses the column strobe once per word while the column address steps up by one. It takes the word from the data pins in the last cycle of each column-strobe high phase. The EDO part keeps its output driven after the column strobe rises, so there is no need to hold the strobe low until capture. Each word is placed in a register and shown to the client with a one-cycle valid pulse, in column order.

A request carries a row, a start column and a length. A burst that would run past the last column of the row is cut short there, and a truncation flag is set. A burst that would keep the row strobe low longer than a parameterised cycle budget is cut short to fit, and an error flag is set. Phase lengths are parameters counted in clock cycles, so the controller can meet the part's page cycle, precharge and strobe-hold minimums at the clock it runs on.

Top module: `edo_burst_reader`

## Requirements
- R1: While reset is held and on the first cycle after it, ras_n, cas_n, we_n and oe_n are all 1, and rd_valid, busy and done are all 0.
- R2: In idle, a start with a non-zero length is accepted. A start with length 0 is ignored: busy stays 0 and ras_n stays 1.
- R3: An accepted burst of n words drops ras_n exactly once, with the row on addr in the first low cycle. It keeps ras_n low for exactly RCD_CYC + n*(CASL_CYC+CP_CYC) + TAIL_CYC cycles, then holds it high for RP_CYC cycles before done.
- R4: Each of the n column-strobe falls presents a column on addr. The first is the start column and each later one is the previous column plus 1. cas_n stays low CASL_CYC cycles and high at least CP_CYC cycles between falls.
- R5: Each word is taken from dram_dq in the last cycle of its cas_n-high phase. It appears on rd_data with rd_valid high for exactly one cycle in the next cycle. Exactly n words are delivered, in column order.
- R6: Let n1 = min(len, 2**COL_W - col). If len > 2**COL_W - col, then truncated is 1; otherwise it is 0.
- R7: Let MAXW = (MAX_RAS_CYC - RCD_CYC - TAIL_CYC) / (CASL_CYC + CP_CYC). Then n = min(n1, MAXW). ras_err is 1 exactly when n1 > MAXW, and the row strobe is never low for more than MAX_RAS_CYC consecutive cycles.
- R8: we_n is 1 on every cycle. oe_n equals ras_n on every cycle. cas_n is 0 only while ras_n is 0.
- R9: A start while busy is 1 is ignored. The running burst's words, length and flags are unchanged.
- R10: done is a one-cycle pulse that comes after ras_n has returned high. truncated and ras_err keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled in idle |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | First column |
| req_len | input | COL_W+1 | Words requested, 1 to 2**COL_W |
| ras_n | output | 1 | Row strobe to DRAM, active low |
| cas_n | output | 1 | Column strobe to DRAM, active low |
| we_n | output | 1 | Write enable to DRAM, held high |
| oe_n | output | 1 | Output enable to DRAM, active low |
| addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq | input | DATA_W | Read data from DRAM |
| rd_data | output | DATA_W | Captured word |
| rd_valid | output | 1 | One-cycle word strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| truncated | output | 1 | Burst was cut at the row end |
| ras_err | output | 1 | Burst was cut to fit the row-strobe budget |

## Verification
The checker watches the strobe protocol on every cycle. It checks that the column strobe falls only inside a row-open period and only with the output enabled, that the column steps by one on each fall, that the column precharge lasts long enough, that the row-low time stays within budget, and that valid pulses and done are single cycles. The bench scenarios are the only place where the data itself is checked: which words arrive, how many, and how the truncation and budget limits combine for each start column and length. They also show the exact row-strobe duration, that zero-length and mid-burst starts are ignored, and that the flags are held.

// File: rtl/edo_burst_pkg.sv
// Package: shared state type for the EDO burst read sequencer.
package edo_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // row closed, waiting for a request
        ST_ROW,    // row strobe low, row address held
        ST_CASL,   // column strobe low, column latched by DRAM
        ST_CASH,   // column strobe high, EDO data still driven
        ST_TAIL,   // row hold after the last column precharge
        ST_PRE     // row strobe high, precharge
    } seq_state_t;
endpackage

// File: rtl/edo_burst_plan.sv
// edo_burst_plan: works out how many words a request may read.
// The count is clipped first at the end of the row and then at the row-strobe
// budget. Purely combinational; assumes MAX_RAS_CYC leaves room for one word.
module edo_burst_plan #(
    parameter int COL_W       = 9,
    parameter int RCD_CYC     = 1,
    parameter int CASL_CYC    = 1,
    parameter int CP_CYC      = 1,
    parameter int TAIL_CYC    = 1,
    parameter int MAX_RAS_CYC = 10000
) (
    input  logic [COL_W-1:0] col,
    input  logic [COL_W:0]   len,
    output logic [COL_W:0]   words,
    output logic             cut_row,
    output logic             cut_ras
);
    localparam int LEN_W     = COL_W + 1;
    localparam int MAX_WORDS = (MAX_RAS_CYC - RCD_CYC - TAIL_CYC) / (CASL_CYC + CP_CYC);
    localparam int MW_CAP    = (MAX_WORDS > (2 ** COL_W)) ? (2 ** COL_W) : MAX_WORDS;
    localparam logic [LEN_W-1:0] COLS  = LEN_W'(1) << COL_W;
    localparam logic [LEN_W-1:0] MW_L  = LEN_W'(MW_CAP);

    logic [LEN_W-1:0] avail;
    logic [LEN_W-1:0] n1;

    // Clip to the row end, then to the row-strobe budget.
    always_comb begin
        avail   = COLS - {1'b0, col};
        cut_row = (len > avail);
        n1      = cut_row ? avail : len;
        cut_ras = (n1 > MW_L);
        words   = cut_ras ? MW_L : n1;
    end
endmodule

// File: rtl/edo_burst_fsm.sv
// edo_burst_fsm: strobe sequencer for one page-mode read burst.
// Phase lengths are in clock cycles; each must be at least 1. Outputs are
// decoded from the registered state, so they change only at clock edges.
module edo_burst_fsm
    import edo_burst_pkg::*;
#(
    parameter int ROW_W    = 9,
    parameter int COL_W    = 9,
    parameter int RCD_CYC  = 1,
    parameter int CASL_CYC = 1,
    parameter int CP_CYC   = 1,
    parameter int TAIL_CYC = 1,
    parameter int RP_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W:0]   words,
    input  logic             cut_row,
    input  logic             cut_ras,
    output logic             ras_n,
    output logic             cas_n,
    output logic             oe_n,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q,
    output logic             addr_is_row,
    output logic             capture,
    output logic             busy,
    output logic             done,
    output logic             truncated,
    output logic             ras_err
);
    localparam int T_W = $clog2(RCD_CYC + CASL_CYC + CP_CYC + TAIL_CYC + RP_CYC + 1);

    seq_state_t       state;
    logic [T_W-1:0]   tcnt;
    logic [T_W-1:0]   lim;
    logic [COL_W:0]   left;
    logic             last_tick;

    // Pick the final count value of the current phase.
    always_comb begin
        case (state)
            ST_ROW:  lim = T_W'(RCD_CYC - 1);
            ST_CASL: lim = T_W'(CASL_CYC - 1);
            ST_CASH: lim = T_W'(CP_CYC - 1);
            ST_TAIL: lim = T_W'(TAIL_CYC - 1);
            ST_PRE:  lim = T_W'(RP_CYC - 1);
            default: lim = '0;
        endcase
        last_tick = (tcnt == lim);
    end

    // Decode the DRAM strobes and the capture point from the state.
    always_comb begin
        ras_n       = (state == ST_IDLE) || (state == ST_PRE);
        cas_n       = (state != ST_CASL);
        oe_n        = ras_n;
        addr_is_row = (state != ST_CASL) && (state != ST_CASH);
        capture     = (state == ST_CASH) && last_tick;
        busy        = (state != ST_IDLE);
    end

    // Advance phases, count words and step the column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            left      <= '0;
            row_q     <= '0;
            col_q     <= '0;
            done      <= 1'b0;
            truncated <= 1'b0;
            ras_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            tcnt <= last_tick ? '0 : tcnt + 1'b1;
            case (state)
                ST_IDLE: begin
                    tcnt <= '0;
                    if (accept) begin
                        row_q     <= row;
                        col_q     <= col;
                        left      <= words;
                        truncated <= cut_row;
                        ras_err   <= cut_ras;
                        state     <= ST_ROW;
                    end
                end
                ST_ROW:  if (last_tick) state <= ST_CASL;
                ST_CASL: if (last_tick) state <= ST_CASH;
                ST_CASH: if (last_tick) begin
                    if (left == 1) begin
                        state <= ST_TAIL;
                    end else begin
                        left  <= left - 1'b1;
                        col_q <= col_q + 1'b1;
                        state <= ST_CASL;
                    end
                end
                ST_TAIL: if (last_tick) state <= ST_PRE;
                ST_PRE:  if (last_tick) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/edo_burst_capture.sv
// edo_burst_capture: registers one DRAM word per column and raises a
// one-cycle valid. Assumes the DRAM keeps data driven while CAS is high.
module edo_burst_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    // Take the word at the capture point and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= dq;
        end
    end
endmodule

// File: rtl/edo_burst_reader.sv
// edo_burst_reader: top of the EDO page-mode burst read sequencer.
// Accepts a request only in idle with a non-zero length. Multiplexes row and
// column onto one address bus; write enable is held inactive.
module edo_burst_reader #(
    parameter int ROW_W       = 9,
    parameter int COL_W       = 9,
    parameter int DATA_W      = 16,
    parameter int RCD_CYC     = 1,
    parameter int CASL_CYC    = 1,
    parameter int CP_CYC      = 1,
    parameter int TAIL_CYC    = 1,
    parameter int RP_CYC      = 2,
    parameter int MAX_RAS_CYC = 10000,
    localparam int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [COL_W:0]    req_len,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dram_dq,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              truncated,
    output logic              ras_err
);
    logic [COL_W:0]   words;
    logic             cut_row, cut_ras, accept, capture, addr_is_row;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    // Accept a request only when idle and non-empty.
    always_comb begin
        accept = start && !busy && (req_len != '0);
        we_n   = 1'b1;
        addr   = addr_is_row ? ADDR_W'(row_q) : ADDR_W'(col_q);
    end

    edo_burst_plan #(
        .COL_W(COL_W), .RCD_CYC(RCD_CYC), .CASL_CYC(CASL_CYC),
        .CP_CYC(CP_CYC), .TAIL_CYC(TAIL_CYC), .MAX_RAS_CYC(MAX_RAS_CYC)
    ) u_plan (
        .col(req_col), .len(req_len), .words(words),
        .cut_row(cut_row), .cut_ras(cut_ras)
    );

    edo_burst_fsm #(
        .ROW_W(ROW_W), .COL_W(COL_W), .RCD_CYC(RCD_CYC), .CASL_CYC(CASL_CYC),
        .CP_CYC(CP_CYC), .TAIL_CYC(TAIL_CYC), .RP_CYC(RP_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .accept(accept), .row(req_row), .col(req_col),
        .words(words), .cut_row(cut_row), .cut_ras(cut_ras),
        .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .row_q(row_q), .col_q(col_q),
        .addr_is_row(addr_is_row), .capture(capture), .busy(busy), .done(done),
        .truncated(truncated), .ras_err(ras_err)
    );

    edo_burst_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .capture(capture), .dq(dram_dq),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/edo_burst_checker.sv
// edo_burst_checker: protocol properties for edo_burst_reader, bound below.
module edo_burst_checker #(
    parameter int COL_W       = 9,
    parameter int ADDR_W      = 9,
    parameter int CP_CYC      = 1,
    parameter int MAX_RAS_CYC = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_valid,
    input logic              done
);
    int               ras_cnt;
    int               hi_cnt;
    logic             cas_q;
    logic             have_col;
    logic [COL_W-1:0] last_col;
    logic             cas_fall;

    always_comb cas_fall = !cas_n && cas_q && !ras_n;

    // Track row-low length, CAS-high length and the last latched column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_cnt  <= 0;
            hi_cnt   <= 0;
            cas_q    <= 1'b1;
            have_col <= 1'b0;
            last_col <= '0;
        end else begin
            cas_q   <= cas_n;
            ras_cnt <= ras_n ? 0 : ras_cnt + 1;
            hi_cnt  <= cas_n ? ((hi_cnt < 1000) ? hi_cnt + 1 : hi_cnt) : 0;
            if (ras_n) have_col <= 1'b0;
            else if (cas_fall) begin
                have_col <= 1'b1;
                last_col <= addr[COL_W-1:0];
            end
        end
    end

    AST_CAS_INSIDE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);                                               // R8
    AST_OE_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !oe_n);                                                // R8
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && have_col) |-> (addr[COL_W-1:0] == last_col + 1'b1)); // R4
    AST_CAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && have_col) |-> (hi_cnt >= CP_CYC));                  // R4
    AST_RAS_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (ras_cnt < MAX_RAS_CYC));                              // R7
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                          // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R10
    AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ras_n && cas_n));                                       // R10
endmodule

bind edo_burst_reader edo_burst_checker #(
    .COL_W(COL_W), .ADDR_W(ADDR_W), .CP_CYC(CP_CYC), .MAX_RAS_CYC(MAX_RAS_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .addr(addr), .rd_valid(rd_valid), .done(done)
);

// File: tb/edo_burst_reader_test.sv
module edo_burst_reader_test;
    localparam int ROW_W = 6, COL_W = 4, DATA_W = 16;
    localparam int RCD = 1, CASL = 1, CP = 1, TAIL = 1, RP = 2, MAXRAS = 22;
    localparam int MAXW = (MAXRAS - RCD - TAIL) / (CASL + CP);
    localparam int COLS = 2 ** COL_W;
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic clk = 0, rst_n = 0, start = 0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [COL_W:0]   req_len = '0;
    logic ras_n, cas_n, we_n, oe_n, rd_valid, busy, done, truncated, ras_err;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dram_dq = '0, rd_data;

    int checks = 0, failures = 0, cycles = 0;
    int row_lat = 0, cas_falls = 0, col_bad = 0, exp_col = 0, ras_falls = 0;
    logic ras_q = 1, cas_q2 = 1;

    edo_burst_reader #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .RCD_CYC(RCD),
        .CASL_CYC(CASL), .CP_CYC(CP), .TAIL_CYC(TAIL), .RP_CYC(RP),
        .MAX_RAS_CYC(MAXRAS)
    ) uut (.*);

    always #10 clk = ~clk;

    function automatic logic [15:0] wordf(int r, int c);
        return 16'((r * 291) ^ (c * 4369) ^ 23130);
    endfunction

    // DRAM model: row latched on RAS fall, column on CAS fall, EDO data held.
    always @(negedge clk) begin
        if (ras_q && !ras_n) begin
            row_lat = int'(addr);
            ras_falls++;
        end
        if (!ras_n && !cas_n && cas_q2) begin
            if (int'(addr) != exp_col) col_bad++;
            exp_col++;
            cas_falls++;
            dram_dq = wordf(row_lat, int'(addr));
        end
        if (!ras_q && ras_n) dram_dq = 16'hDEAD;
        ras_q  = ras_n;
        cas_q2 = cas_n;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(int row, int col, int len, bit poke);
        int avail, n1, n, exp_tr, exp_er, widx, ras_lo, bad_we, bad_oe, k, got;
        avail  = COLS - col;
        n1     = (len < avail) ? len : avail;
        exp_tr = (len > avail);
        n      = (n1 < MAXW) ? n1 : MAXW;
        exp_er = (n1 > MAXW);
        cas_falls = 0; col_bad = 0; exp_col = col; ras_falls = 0;
        @(negedge clk);
        start = 1; req_row = ROW_W'(row); req_col = COL_W'(col); req_len = (COL_W+1)'(len);
        @(negedge clk);
        start = 0;
        if (len == 0) begin
            got = 0;
            for (int i = 0; i < 5; i++) begin
                if (busy || !ras_n) got++;
                @(negedge clk);
            end
            chk("R2 zero length ignored", got, 0);
            return;
        end
        widx = 0; ras_lo = 0; bad_we = 0; bad_oe = 0; k = 0; got = 0;
        while (!got && k < 200) begin
            if (poke && k == 2) begin
                start = 1; req_row = ROW_W'(row ^ 1); req_col = '0; req_len = 3;
            end
            if (poke && k == 3) start = 0;
            if (!ras_n) ras_lo++;
            if (we_n !== 1'b1) bad_we++;
            if (oe_n !== ras_n) bad_oe++;
            if (rd_valid) begin
                chk("R5 word data", int'(rd_data), int'(wordf(row, col + widx)));
                widx++;
            end
            if (done) begin
                got = 1;
                chk("R10 done after row closed", int'(ras_n), 1);
            end else begin
                @(negedge clk);
                k++;
            end
        end
        chk("R10 done seen", got, 1);
        chk("R5 word count", widx, n);
        chk("R3 row-low cycles", ras_lo, RCD + n * (CASL + CP) + TAIL);
        chk("R3 single RAS fall", ras_falls, 1);
        chk("R3 row address", row_lat, row);
        chk("R4 CAS falls", cas_falls, n);
        chk("R4 column order", col_bad, 0);
        chk("R6 truncated", int'(truncated), exp_tr);
        chk("R7 ras_err", int'(ras_err), exp_er);
        chk("R8 we_n high", bad_we, 0);
        chk("R8 oe_n tracks ras_n", bad_oe, 0);
        @(negedge clk);
        chk("R10 done single pulse", int'(done), 0);
        chk("R10 flags held", int'({truncated, ras_err}), exp_tr * 2 + exp_er);
        if (poke) chk("R9 busy start ignored", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", int'({ras_n, cas_n, we_n, oe_n}), 15);
        chk("R1 reset status", int'({rd_valid, busy, done}), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset strobes", int'({ras_n, cas_n, we_n, oe_n}), 15);
        chk("R1 after reset status", int'({rd_valid, busy, done}), 0);
        for (int c = 0; c < COLS; c++)
            for (int l = 0; l <= COLS + 1; l++)
                run((c * 7 + l * 3) % (2 ** ROW_W), c, l, 1'b0);
        run(5, 2, 4, 1'b1);   // R9 start during a burst
        run(9, 0, 16, 1'b1);  // R9 with R7 cut
        run(63, 15, 1, 1'b0); // R6 last column single word
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule